// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits on the processor side of a host-to-PCI bridge. Each requested address is compared against a set of windows that are fixed at elaboration. A window is given by a base address, a high address, a relocation vector and a space tag. The base and high addresses must bound a naturally aligned block whose size is a power of two. The space tag marks the window as memory space or I/O space.

When an address lands in a window, the block keeps the offset bits inside that window. It replaces every bit above the window size with the corresponding bits of the relocation vector. It then rounds the result down to an 8-byte boundary and reports the window number and the space type.

When no window claims the address, the block flags a miss so that the requester can end the access with an error. Decoding is purely combinational. The result appears on registered outputs in the cycle after the request strobe.

Top module: `outbound_addr_xlat`

## Requirements
- R1: A request with `in_valid`=1 whose address A satisfies base ≤ A ≤ high for at least one window produces `out_hit`=1 on the following clock edge.
- R2: When several windows contain the address, `out_idx` reports the lowest-numbered of them, and the translation and space type come from that window.
- R3: On a hit, the translated address takes its bits above the window size (mask = high − base) from that window's relocation vector and its bits inside the window from the request address, before alignment.
- R4: On a hit, `out_io` equals the window's space tag, where 1 means I/O space and 0 means memory space.
- R5: Bits [2:0] of `out_addr` are always zero, so the outgoing address is rounded down to an 8-byte boundary.
- R6: A request that matches no window gives `out_miss`=1 and `out_hit`=0 in the following cycle, with `out_idx`, `out_addr` and `out_io` all zero.
- R7: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid`=1. Each request's result appears on the outputs one clock edge after it is presented.
- R8: While `in_valid`=0, `out_valid` and `out_miss` go to 0. `out_hit`, `out_idx`, `out_addr` and `out_io` hold their last values regardless of `in_addr`.
- R9: After asynchronous reset (`rst_n`=0), every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_addr | input | ADDR_W | Processor-side request address |
| out_valid | output | 1 | Result strobe, one cycle after request |
| out_hit | output | 1 | Address fell inside a window |
| out_miss | output | 1 | Request claimed by no window |
| out_idx | output | IDX_W | Number of the winning window |
| out_addr | output | ADDR_W | Translated, 8-byte aligned PCI address |
| out_io | output | 1 | Space type: 1 = I/O, 0 = memory |

## Verification
The bench builds the block with a 12-bit address and four windows. Window 0 covers 128 bytes at 0x100 and goes to memory space. Window 1 covers 256 bytes at 0x400 and goes to I/O space. Window 2 covers 32 bytes at 0x140, entirely inside window 0, so it checks priority. Window 3 covers 1 KiB at 0x800 and goes to I/O space.

With a 4096-entry address space, every address can be swept back to back. That sweep reaches every window edge, every one-past-the-end miss, the overlap and every alignment case. The bench computes each expected result with range compares and divide/modulo arithmetic. Separate idle and reset phases check output holding and the reset state.

// File: rtl/aw_pkg.sv
package aw_pkg;
  typedef enum logic {
    SPACE_MEM = 1'b0,
    SPACE_IO  = 1'b1
  } space_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/aw_window_match.sv
module aw_window_match #(
  parameter int               ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE  = '0,
  parameter logic [ADDR_W-1:0] HIGH  = '1,
  parameter logic [ADDR_W-1:0] XLAT  = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] xaddr
);
  localparam logic [ADDR_W-1:0] SPAN_MASK = HIGH - BASE;

  function automatic logic in_window(input logic [ADDR_W-1:0] a);
    return (a & ~SPAN_MASK) == (BASE & ~SPAN_MASK);
  endfunction

  function automatic logic [ADDR_W-1:0] relocate(input logic [ADDR_W-1:0] a);
    return (XLAT & ~SPAN_MASK) | (a & SPAN_MASK);
  endfunction

  function automatic logic [ADDR_W-1:0] dword_floor(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:3], 3'b000};
  endfunction

  always_comb begin
    hit   = in_window(addr);
    xaddr = dword_floor(relocate(addr));
  end
endmodule

// File: rtl/aw_first_hit.sv
module aw_first_hit #(
  parameter int                 NUM_WIN = 6,
  parameter int                 ADDR_W  = 32,
  parameter int                 IDX_W   = 3,
  parameter logic [NUM_WIN-1:0] IS_IO   = '0
) (
  input  logic [NUM_WIN-1:0]             match,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] cand,
  output logic [NUM_WIN-1:0]             grant,
  output logic                           any,
  output logic [IDX_W-1:0]               idx,
  output logic [ADDR_W-1:0]              addr,
  output logic                           io
);
  always_comb begin
    grant = '0;
    idx   = '0;
    addr  = '0;
    io    = 1'b0;
    any   = |match;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
        addr     = cand[i];
        io       = IS_IO[i];
      end
    end
  end
endmodule

// File: rtl/aw_out_reg.sv
module aw_out_reg #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              pick_hit,
  input  logic [IDX_W-1:0]  pick_idx,
  input  logic [ADDR_W-1:0] pick_addr,
  input  logic              pick_io,
  output logic              out_valid,
  output logic              out_hit,
  output logic              out_miss,
  output logic [IDX_W-1:0]  out_idx,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_io
);
  logic take_hit, take_miss;
  assign take_hit  = in_valid & pick_hit;
  assign take_miss = in_valid & ~pick_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_miss  <= 1'b0;
      out_idx   <= '0;
      out_addr  <= '0;
      out_io    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_miss  <= take_miss;
      if (take_hit) begin
        out_hit  <= 1'b1;
        out_idx  <= pick_idx;
        out_addr <= pick_addr;
        out_io   <= pick_io;
      end else if (take_miss) begin
        out_hit  <= 1'b0;
        out_idx  <= '0;
        out_addr <= '0;
        out_io   <= 1'b0;
      end
    end
  end

  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_hit && out_miss)); // R6
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_miss |-> (out_addr == '0 && out_idx == '0 && !out_io)); // R6
  AST_OUT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    out_addr[2:0] == 3'b000); // R5
  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_miss)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_addr) && $stable(out_idx) && $stable(out_hit))); // R8
endmodule

// File: rtl/outbound_addr_xlat.sv
module outbound_addr_xlat #(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 6,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_BASE = {
    32'hF000_0000, 32'hE000_0000, 32'hC000_0000,
    32'hA000_0000, 32'h9000_0000, 32'h8000_0000},
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_HIGH = {
    32'hF000_FFFF, 32'hE0FF_FFFF, 32'hDFFF_FFFF,
    32'hA00F_FFFF, 32'h9FFF_FFFF, 32'h8FFF_FFFF},
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_XLAT = {
    32'h0000_0000, 32'h1000_0000, 32'h4000_0000,
    32'h0010_0000, 32'h2000_0000, 32'h0000_0000},
  parameter logic [NUM_WIN-1:0] WIN_IS_IO = 6'b100000,
  localparam int IDX_W = aw_pkg::idx_width(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  output logic              out_hit,
  output logic              out_miss,
  output logic [IDX_W-1:0]  out_idx,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_io
);
  logic [NUM_WIN-1:0]             win_match;
  logic [NUM_WIN-1:0][ADDR_W-1:0] win_xaddr;
  logic [NUM_WIN-1:0]             win_grant;
  logic                           pick_hit;
  logic [IDX_W-1:0]               pick_idx;
  logic [ADDR_W-1:0]              pick_addr;
  logic                           pick_io;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    aw_window_match #(
      .ADDR_W (ADDR_W),
      .BASE   (WIN_BASE[w]),
      .HIGH   (WIN_HIGH[w]),
      .XLAT   (WIN_XLAT[w])
    ) u_match (
      .addr  (in_addr),
      .hit   (win_match[w]),
      .xaddr (win_xaddr[w])
    );
  end

  aw_first_hit #(
    .NUM_WIN (NUM_WIN),
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W),
    .IS_IO   (WIN_IS_IO)
  ) u_pick (
    .match (win_match),
    .cand  (win_xaddr),
    .grant (win_grant),
    .any   (pick_hit),
    .idx   (pick_idx),
    .addr  (pick_addr),
    .io    (pick_io)
  );

  aw_out_reg #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .pick_hit  (pick_hit),
    .pick_idx  (pick_idx),
    .pick_addr (pick_addr),
    .pick_io   (pick_io),
    .out_valid (out_valid),
    .out_hit   (out_hit),
    .out_miss  (out_miss),
    .out_idx   (out_idx),
    .out_addr  (out_addr),
    .out_io    (out_io)
  );

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_grant)); // R2
  AST_GRANT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|win_grant) == (|win_match)); // R1
  AST_HIT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && |win_match) |=> out_hit); // R1
  AST_IO_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pick_hit) |=> (out_io == $past(WIN_IS_IO[pick_idx]))); // R4
endmodule

// File: tb/outbound_addr_xlat_test.sv
module outbound_addr_xlat_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int NW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic          out_valid, out_hit, out_miss, out_io;
  logic [1:0]    out_idx;
  logic [AW-1:0] out_addr;

  int checks = 0;
  int failures = 0;

  int t_base [NW] = '{'h100, 'h400, 'h140, 'h800};
  int t_high [NW] = '{'h17F, 'h4FF, 'h15F, 'hBFF};
  int t_xlat [NW] = '{'hA00, 'h300, 'hE00, 'h000};
  int t_io   [NW] = '{0, 1, 0, 1};

  always #(CLK_PERIOD/2) clk = ~clk;

  outbound_addr_xlat #(
    .ADDR_W    (AW),
    .NUM_WIN   (NW),
    .WIN_BASE  ({12'h800, 12'h140, 12'h400, 12'h100}),
    .WIN_HIGH  ({12'hBFF, 12'h15F, 12'h4FF, 12'h17F}),
    .WIN_XLAT  ({12'h000, 12'hE00, 12'h300, 12'hA00}),
    .WIN_IS_IO (4'b1010)
  ) uut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_addr (in_addr),
    .out_valid (out_valid), .out_hit (out_hit), .out_miss (out_miss),
    .out_idx (out_idx), .out_addr (out_addr), .out_io (out_io)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s addr=0x%03h actual=0x%0h expected=0x%0h", tag, in_addr, act, exp);
    end
  endtask

  task automatic expect_for(input int a, output int hit, output int idx,
                            output int xa, output int io);
    hit = 0; idx = 0; xa = 0; io = 0;
    for (int w = 0; w < NW; w++) begin
      if (hit == 0 && a >= t_base[w] && a <= t_high[w]) begin
        int size = t_high[w] - t_base[w] + 1;
        int raw = (t_xlat[w] / size) * size + (a % size);
        hit = 1; idx = w; io = t_io[w];
        xa = raw - (raw % 8);
      end
    end
  endtask

  task automatic request(input int a);
    int eh, ei, ex, eo;
    @(negedge clk);
    in_valid = 1'b1;
    in_addr  = AW'(a);
    expect_for(a, eh, ei, ex, eo);
    @(posedge clk);
    #1;
    check("R7 out_valid", int'(out_valid), 1);
    check("R1 out_hit", int'(out_hit), eh);
    check("R6 out_miss", int'(out_miss), 1 - eh);
    check("R2 out_idx", int'(out_idx), ei);
    check("R3 out_addr", int'(out_addr), ex);
    check("R4 out_io", int'(out_io), eo);
    check("R5 low bits", int'(out_addr[2:0]), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 out_valid reset", int'(out_valid), 0);
    check("R9 out_hit reset", int'(out_hit), 0);
    check("R9 out_miss reset", int'(out_miss), 0);
    check("R9 out_addr reset", int'(out_addr), 0);
    check("R9 out_idx reset", int'(out_idx), 0);
    check("R9 out_io reset", int'(out_io), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Named edges: R1 low/high edge of window 0, R6 one past the end, R2 overlap
    request('h100);
    request('h17F);
    request('h180);
    request('h0FF);
    request('h147);
    request('h4FF);
    request('h500);
    request('hBFF);
    request('hC00);

    // Exhaustive sweep of the 12-bit space
    for (int a = 0; a < (1 << AW); a++) request(a);

    // R8: idle cycles hold results and quiet the strobes
    request('h41D);
    @(negedge clk);
    in_valid = 1'b0;
    in_addr  = 12'h000;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      #1;
      check("R8 out_valid idle", int'(out_valid), 0);
      check("R8 out_miss idle", int'(out_miss), 0);
      check("R8 out_hit hold", int'(out_hit), 1);
      check("R8 out_addr hold", int'(out_addr), 'h318);
      check("R8 out_idx hold", int'(out_idx), 1);
      check("R8 out_io hold", int'(out_io), 1);
      @(negedge clk);
      in_addr = AW'(k * 'h155);
    end

    // R9: reset mid-run clears everything
    rst_n = 1'b0;
    #1;
    check("R9 out_hit async", int'(out_hit), 0);
    check("R9 out_addr async", int'(out_addr), 0);
    check("R9 out_idx async", int'(out_idx), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule